// File: doc/BRIEF.md
# Variable-Rate Sine Sample Sequencer

This block produces a stream of 8-bit unsigned sine samples for a resistor-ladder DAC outside the chip. One full sine period is stored as a 256-entry table. The table holds offset-binary values centred on 128. A phase index steps through the table. The step size follows a resolution setting of 256, 128, 64, 32, 16 or 8 samples per period. Each sample stays on the output for a hold time set by a 16-bit delay constant. The output frequency is therefore f_clk / (samples_per_period × (4 × D + 13)).

A level-sensitive stop input freezes the sequence in the cycle it is raised. A load strobe captures a new resolution code and delay constant, returns the index to zero and restarts the hold timer. The new setting is in force from that cycle on. A one-cycle wrap pulse marks each return of the index to zero through normal stepping. After reset the block runs at a start-up resolution and delay given as parameters.

Top module: `sine_seq`

## Requirements
- R1: After reset the index is 0, so sample_o is 128 and wrap_o is low. The block then runs at the START_RES code and the START_DLY delay (defaults: code 0 and delay 1, which gives a hold of 17 cycles).
- R2: For a delay constant D in 1..65535, every sample is held for exactly 4 × D + 13 clock cycles while stop_i is low. The shortest hold is 17 cycles.
- R3: A delay constant of 0 acts as 65536, which gives a hold of 262157 cycles.
- R4: A resolution code c in 0..5 sets the index stride to 2^c, giving 256 >> c samples per period. Codes 6 and 7 act as code 5. The index wraps modulo 256.
- R5: For index i, sample_o equals 128 + 127·sin(2πi/256), rounded, to within 1 LSB. It is exactly 128 at i = 0, 255 at i = 64 and 1 at i = 192.
- R6: wrap_o is high for exactly one cycle. That cycle is the first one in which a step has brought the index back to 0. wrap_o stays low on reset and on load.
- R7: While stop_i is high and load_i is low, the index and the hold timer do not move and wrap_o is low. When stop_i falls, the hold resumes with the cycles it still had left.
- R8: A load_i pulse captures load_res_i and load_dly_i, sets the index to 0 and restarts the hold timer. The first step comes 4 × D + 13 cycles after the load edge. A load also takes effect while stop_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_i | input | 1 | Freeze the sequence while high |
| load_i | input | 1 | Strobe that captures a new setting and restarts the sequence |
| load_res_i | input | 3 | Resolution code (stride 2^code) |
| load_dly_i | input | 16 | Delay constant (0 means 65536) |
| sample_o | output | 8 | Sine sample, offset binary |
| wrap_o | output | 1 | One-cycle pulse when the index wraps to 0 |

## Verification
The case hardest to reach from the ports is a stop that falls in the middle of a hold, after part of the hold count has already been used. The stimulus loads a setting and runs a few samples into it. It then raises stop for a stretch that is not a multiple of the hold. After release it checks every cycle against a model whose time count advances only on edges where stop was low, so a timer that restarts the hold or slips by a cycle shows up. A load issued while stop is held is checked the same way. The very long hold for delay 0 is covered by a run much longer than any short hold, with no step expected.

// File: rtl/sine_seq_pkg.sv
package sine_seq_pkg;

  // Rational sine approximation over one half period, rounded to nearest.
  function automatic int sine_value(int i, int idx_w, int smp_w);
    int half, j, p, amp, mid, num, den, s;
    half = 1 << (idx_w - 1);
    amp  = (1 << (smp_w - 1)) - 1;
    mid  = 1 << (smp_w - 1);
    j    = i % half;
    p    = j * (half - j);
    num  = 32 * amp * p;
    den  = 5 * half * half - 4 * p;
    s    = (num / den + 1) / 2;
    return (i < half) ? mid + s : mid - s;
  endfunction

endpackage

// File: rtl/sine_rom.sv
module sine_rom #(
  parameter int IDX_W = 8,
  parameter int SMP_W = 8
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [SMP_W-1:0] sample_o
);
  import sine_seq_pkg::*;

  localparam int DEPTH = 1 << IDX_W;

  logic [SMP_W-1:0] table_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam logic [SMP_W-1:0] VAL = SMP_W'(sine_value(g, IDX_W, SMP_W));
    assign table_w[g] = VAL;
  end

  assign sample_o = table_w[idx_i];

endmodule

// File: rtl/seq_cfg.sv
module seq_cfg #(
  parameter int IDX_W     = 8,
  parameter int DLY_W     = 16,
  parameter int RES_W     = 3,
  parameter int START_RES = 0,
  parameter int START_DLY = 1,
  parameter int CNT_W     = DLY_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [RES_W-1:0] res_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic [IDX_W-1:0] stride_o,
  output logic [CNT_W-1:0] period_m1_o
);
  localparam int MAX_CODE_I = IDX_W - 3;
  localparam logic [RES_W-1:0] MAX_CODE   = RES_W'(MAX_CODE_I);
  localparam logic [RES_W-1:0] START_CODE =
    RES_W'((START_RES > MAX_CODE_I) ? MAX_CODE_I : START_RES);

  logic [RES_W-1:0] res_q;
  logic [DLY_W-1:0] dly_q;
  logic [CNT_W-1:0] dly_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= START_CODE;
      dly_q <= DLY_W'(START_DLY);
    end else if (load_i) begin
      res_q <= (res_i > MAX_CODE) ? MAX_CODE : res_i;
      dly_q <= dly_i;
    end
  end

  // zero delay stands for 2^DLY_W
  assign dly_ext     = (dly_q == '0) ? (CNT_W'(1) << DLY_W) : CNT_W'(dly_q);
  assign period_m1_o = (dly_ext << 2) + CNT_W'(12);
  assign stride_o    = IDX_W'(1) << res_q;

endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int CNT_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_m1_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == period_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (restart_i)   cnt_q <= '0;
    else if (run_i)       cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
  end

  assign tick_o = run_i && !restart_i && at_end;

endmodule

// File: rtl/phase_step.sv
module phase_step #(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [IDX_W-1:0] stride_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             wrap_o
);
  logic [IDX_W-1:0] idx_q, idx_next;
  logic             wrap_q;

  assign idx_next = idx_q + stride_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      wrap_q <= 1'b0;
    end else if (restart_i) begin
      idx_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= tick_i && (idx_next == '0);
      if (tick_i) idx_q <= idx_next;
    end
  end

  assign idx_o  = idx_q;
  assign wrap_o = wrap_q;

endmodule

// File: rtl/sine_seq.sv
module sine_seq #(
  parameter int IDX_W     = 8,
  parameter int SMP_W     = 8,
  parameter int DLY_W     = 16,
  parameter int RES_W     = 3,
  parameter int START_RES = 0,
  parameter int START_DLY = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic             load_i,
  input  logic [RES_W-1:0] load_res_i,
  input  logic [DLY_W-1:0] load_dly_i,
  output logic [SMP_W-1:0] sample_o,
  output logic             wrap_o
);
  localparam int CNT_W = DLY_W + 3;

  logic [IDX_W-1:0] stride_w;
  logic [CNT_W-1:0] period_m1_w;
  logic [IDX_W-1:0] idx_w;
  logic             tick_w;

  seq_cfg #(
    .IDX_W(IDX_W), .DLY_W(DLY_W), .RES_W(RES_W),
    .START_RES(START_RES), .START_DLY(START_DLY), .CNT_W(CNT_W)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i),
    .res_i(load_res_i), .dly_i(load_dly_i),
    .stride_o(stride_w), .period_m1_o(period_m1_w)
  );

  hold_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(load_i), .run_i(!stop_i),
    .period_m1_i(period_m1_w), .tick_o(tick_w)
  );

  phase_step #(.IDX_W(IDX_W)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(load_i), .tick_i(tick_w),
    .stride_i(stride_w), .idx_o(idx_w), .wrap_o(wrap_o)
  );

  sine_rom #(.IDX_W(IDX_W), .SMP_W(SMP_W)) u_rom (
    .idx_i(idx_w), .sample_o(sample_o)
  );

endmodule

// File: rtl/sine_seq_chk.sv
module sine_seq_chk #(
  parameter int IDX_W = 8,
  parameter int CNT_W = 19
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stop_i,
  input logic             load_i,
  input logic             wrap_o,
  input logic [IDX_W-1:0] idx_i,
  input logic [IDX_W-1:0] stride_i,
  input logic [CNT_W-1:0] period_m1_i
);

  // R7
  stop_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !load_i) |=> (idx_i == $past(idx_i)) && !wrap_o);

  // R6
  wrap_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> (idx_i == '0));

  // R6
  wrap_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> !wrap_o);

  // R8
  load_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (idx_i == '0) && !wrap_o);

  // R4
  step_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(load_i) && (idx_i != $past(idx_i))) |->
      (idx_i == IDX_W'($past(idx_i) + $past(stride_i))));

  // R4
  stride_pow2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(stride_i) == 1);

  // R2
  min_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_m1_i >= CNT_W'(16));

endmodule

bind sine_seq sine_seq_chk #(.IDX_W(IDX_W), .CNT_W(DLY_W + 3)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_i), .load_i(load_i),
  .wrap_o(wrap_o), .idx_i(idx_w), .stride_i(stride_w),
  .period_m1_i(period_m1_w)
);

// File: tb/sine_seq_tb.sv
module sine_seq_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        stop_i = 1'b0;
  logic        load_i = 1'b0;
  logic [2:0]  load_res_i = '0;
  logic [15:0] load_dly_i = '0;
  logic [7:0]  sample_o;
  logic        wrap_o;

  int checks = 0;
  int fails  = 0;
  int eff    = 0;
  int cur_n  = 17;
  int cur_st = 1;
  bit last_adv = 0;

  always #10 clk_i = ~clk_i;

  sine_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_i), .load_i(load_i),
    .load_res_i(load_res_i), .load_dly_i(load_dly_i),
    .sample_o(sample_o), .wrap_o(wrap_o)
  );

  function automatic int exp_sample(int i);
    real v;
    v = 128.0 + 127.0 * $sin(2.0 * 3.14159265358979 * i / 256.0);
    return $rtoi(v + 0.5);
  endfunction

  function automatic int hold_of(int d);
    return 4 * ((d == 0) ? 65536 : d) + 13;
  endfunction

  task automatic check_now(string tag);
    int idx, e, diff;
    bit ew, bad;
    idx  = ((eff / cur_n) * cur_st) % 256;
    e    = exp_sample(idx);
    diff = int'(sample_o) - e;
    bad  = (diff > 1) || (diff < -1);
    if (idx % 64 == 0 && int'(sample_o) != ((idx == 0) ? 128 : (idx == 64) ? 255 : (idx == 128) ? 128 : 1))
      bad = 1;
    ew = last_adv && (idx == 0);
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s sample idx %0d: actual %0d expected %0d", tag, idx, sample_o, e);
    end else if (wrap_o !== ew) begin
      fails++;
      $display("FAIL %s/R6 wrap idx %0d: actual %0b expected %0b", tag, idx, wrap_o, ew);
    end
  endtask

  // called just after a falling edge
  task automatic run(int cycles, bit stop_val, string tag);
    for (int k = 0; k < cycles; k++) begin
      stop_i = stop_val;
      @(posedge clk_i);
      last_adv = 0;
      if (!stop_val) begin
        eff++;
        last_adv = (eff % cur_n == 0);
      end
      @(negedge clk_i);
      check_now(tag);
    end
  endtask

  task automatic do_load(int code, int dly, string tag);
    load_i = 1'b1;
    load_res_i = 3'(code);
    load_dly_i = 16'(dly);
    @(posedge clk_i);
    eff = 0;
    last_adv = 0;
    cur_n = hold_of(dly);
    cur_st = 1 << ((code > 5) ? 5 : code);
    @(negedge clk_i);
    load_i = 1'b0;
    check_now(tag);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state and start-up setting
    check_now("R1");
    run(300, 1'b0, "R1");

    // R4 R5 R6: every code, one full period plus a few samples
    for (int c = 0; c < 8; c++) begin
      do_load(c, 1, "R4");
      run(((256 >> ((c > 5) ? 5 : c)) + 2) * hold_of(1), 1'b0, "R4");
    end
    // R2 longer holds
    for (int c = 0; c < 6; c++) begin
      do_load(c, 2, "R2");
      run(((256 >> c) + 1) * hold_of(2), 1'b0, "R2");
    end
    do_load(5, 300, "R2");
    run(9 * hold_of(300) + 5, 1'b0, "R2");

    // R7 stop in mid-hold, resume with remainder
    do_load(0, 1, "R7");
    run(40, 1'b0, "R7");
    run(50, 1'b1, "R7");
    run(100, 1'b0, "R7");
    run(3, 1'b1, "R7");
    run(60, 1'b0, "R7");

    // R8 load while stopped
    do_load(0, 1, "R8");
    run(25, 1'b0, "R8");
    stop_i = 1'b1;
    do_load(2, 3, "R8");
    run(30, 1'b1, "R8");
    run(8 * hold_of(3) + 3, 1'b0, "R8");

    // R3 delay zero holds far beyond any short hold
    do_load(5, 0, "R3");
    run(3000, 1'b0, "R3");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule